// File: doc/BRIEF.md
# Power-Budget Strap Latch and Class Grant Decoder

This block captures the three power-budget strap inputs and the span-position strap at a handful of well-defined moments, and turns them into a held configuration for the port sequencing controller. That configuration is the highest class the port may grant, whether the port runs over four pairs or as two independent two-pair ports, and whether the strap setting is an illegal combination. Between those moments the straps are not looked at, so board noise or a jumper moved in service cannot change a running port.

The straps are captured on the first clock after reset is released, which is also power-up, and again whenever the supply undervoltage or the over-temperature condition auto-clears. The decoded configuration is registered one clock after the capture and only then marked valid. While it is valid and legal, detection is enabled. The sequencing controller hands each classification result to the block over a valid/ready request channel. The block returns the granted class, demoted to the configured maximum where needed, together with the pair mode to power it with, over a valid/ready grant channel. A request is accepted only on a cycle where both req_valid and req_ready are high. Once presented, a grant holds its value until grant_ready is seen high. Back-pressure on the grant side removes req_ready.

Top module: `pwr_strap_cfg`

## Requirements
- R1: The straps are captured on the first rising edge after rst_n goes high, and cfg_valid rises on the second rising edge after release. All outputs are 0 during reset.
- R2: A one-cycle pulse on uvlo_clear or on otemp_clear captures the straps at that edge. cfg_valid is low for exactly the following cycle and is high again, with the newly decoded values, one edge later.
- R3: Strap changes without a capture event have no effect on max_class, four_pair, cfg_error or detect_en.
- R4: Codes 3'b100, 3'b101, 3'b110 and 3'b111 give max_class 5, 6, 7 and 8 with four_pair=1 and cfg_error=0, whatever the span strap.
- R5: Code 3'b011 with span_strap=1 gives max_class 4 with four_pair=1. With span_strap=0 it is reserved: cfg_error=1, max_class=0, four_pair=0.
- R6: Codes 3'b010, 3'b001 and 3'b000 give max_class 4, 3 and 2 with four_pair=0 (two independent ports), whatever the span strap.
- R7: detect_en is high exactly when cfg_valid is high and cfg_error is low.
- R8: The granted class is the requested class when that does not exceed max_class, and max_class otherwise.
- R9: grant_four_pair is 1 exactly when the configuration is four-pair and the granted class is 4 or more. A class-4 load under a class 5 to 8 maximum is therefore powered over four pairs.
- R10: req_ready is high when detect_en is high and the grant register is empty or grant_ready is high. A grant stalled by grant_ready=0 keeps grant_valid, grant_class and grant_four_pair unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_code | input | 3 | Power-budget strap levels |
| span_strap | input | 1 | Span-position strap, 1 = four-pair capable |
| uvlo_clear | input | 1 | Pulse: undervoltage condition auto-cleared |
| otemp_clear | input | 1 | Pulse: over-temperature condition auto-cleared |
| cfg_valid | output | 1 | Decoded configuration is current |
| max_class | output | 4 | Highest grantable class |
| four_pair | output | 1 | 1 = four-pair mode, 0 = two independent two-pair ports |
| cfg_error | output | 1 | Reserved strap code captured |
| detect_en | output | 1 | Detection may run |
| req_valid | input | 1 | Requested class is presented |
| req_ready | output | 1 | Request can be taken |
| req_class | input | 4 | Class requested by the load |
| grant_valid | output | 1 | Grant is presented |
| grant_ready | input | 1 | Grant consumer takes the grant |
| grant_class | output | 4 | Granted class |
| grant_four_pair | output | 1 | Grant is powered over four pairs |

## Verification
The assertions check on every cycle that the captured strap copy moves only on a capture event, that a fresh capture turns into a valid configuration one edge later, that a reserved code never comes with a nonzero class or four-pair mode, that a taken grant never exceeds the maximum in force when it was taken, that four-pair grants are class 4 or higher, and that a stalled grant holds still. Only the bench scenarios can show that the decode table maps every strap combination correctly, that strap changes with no event leave the outputs alone, and that demotion and the forced four-pair rule pick the right result for each request.

// File: rtl/pwr_strap_pkg.sv
package pwr_strap_pkg;
  localparam int CODE_W = 3;
  localparam int CLS_W  = 4;

  typedef logic [CLS_W-1:0] cls_t;

  typedef struct packed {
    cls_t max_cls;
    logic quad;
    logic bad;
  } strap_cfg_t;

  function automatic strap_cfg_t decode_straps(input logic [CODE_W-1:0] code, input logic span);
    strap_cfg_t r;
    r = '0;
    if (code[CODE_W-1]) begin
      r.max_cls = cls_t'(code) + cls_t'(1);
      r.quad    = 1'b1;
    end else if (code == 3'b011) begin
      if (span) begin
        r.max_cls = cls_t'(4);
        r.quad    = 1'b1;
      end else begin
        r.bad = 1'b1;
      end
    end else begin
      r.max_cls = cls_t'(code) + cls_t'(2);
    end
    return r;
  endfunction
endpackage

// File: rtl/strap_sampler.sv
module strap_sampler
  import pwr_strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] strap_code,
  input  logic              span_strap,
  input  logic              uvlo_clear,
  input  logic              otemp_clear,
  output logic              take_evt,
  output logic              snap_new,
  output logic [CODE_W-1:0] snap_code,
  output logic              snap_span
);
  logic boot_pend;

  assign take_evt = boot_pend | uvlo_clear | otemp_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_pend <= 1'b1;
      snap_new  <= 1'b0;
      snap_code <= '0;
      snap_span <= 1'b0;
    end else begin
      boot_pend <= 1'b0;
      snap_new  <= take_evt;
      if (take_evt) begin
        snap_code <= strap_code;
        snap_span <= span_strap;
      end
    end
  end

  // R3
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_evt |=> ($stable(snap_code) && $stable(snap_span)));
endmodule

// File: rtl/cfg_decoder.sv
module cfg_decoder
  import pwr_strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_evt,
  input  logic              snap_new,
  input  logic [CODE_W-1:0] snap_code,
  input  logic              snap_span,
  output logic              cfg_valid,
  output cls_t              max_class,
  output logic              four_pair,
  output logic              cfg_error
);
  strap_cfg_t dec;

  always_comb dec = decode_straps(snap_code, snap_span);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_valid <= 1'b0;
      max_class <= '0;
      four_pair <= 1'b0;
      cfg_error <= 1'b0;
    end else begin
      if (snap_new) begin
        max_class <= dec.max_cls;
        four_pair <= dec.quad;
        cfg_error <= dec.bad;
      end
      if (take_evt)      cfg_valid <= 1'b0;
      else if (snap_new) cfg_valid <= 1'b1;
    end
  end

  // R2
  valid_after_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_new && !take_evt) |=> cfg_valid);
  // R5
  reserved_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> (max_class == '0 && !four_pair));
endmodule

// File: rtl/grant_stage.sv
module grant_stage
  import pwr_strap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic usable,
  input  cls_t max_class,
  input  logic four_pair,
  input  logic req_valid,
  output logic req_ready,
  input  cls_t req_class,
  output logic grant_valid,
  input  logic grant_ready,
  output cls_t grant_class,
  output logic grant_four_pair
);
  cls_t granted;
  logic take;

  assign req_ready = usable && (!grant_valid || grant_ready);
  assign take      = req_valid && req_ready;
  assign granted   = (req_class > max_class) ? max_class : req_class;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid     <= 1'b0;
      grant_class     <= '0;
      grant_four_pair <= 1'b0;
    end else if (take) begin
      grant_valid     <= 1'b1;
      grant_class     <= granted;
      grant_four_pair <= four_pair && (granted >= cls_t'(4));
    end else if (grant_ready) begin
      grant_valid     <= 1'b0;
    end
  end

  // R8
  no_overgrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (grant_class <= $past(max_class)));
  // R9
  quad_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_four_pair) |-> (grant_class >= cls_t'(4)));
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=> (grant_valid && $stable(grant_class) && $stable(grant_four_pair)));
endmodule

// File: rtl/pwr_strap_cfg.sv
module pwr_strap_cfg
  import pwr_strap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_code,
  input  logic       span_strap,
  input  logic       uvlo_clear,
  input  logic       otemp_clear,
  output logic       cfg_valid,
  output logic [3:0] max_class,
  output logic       four_pair,
  output logic       cfg_error,
  output logic       detect_en,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [3:0] req_class,
  output logic       grant_valid,
  input  logic       grant_ready,
  output logic [3:0] grant_class,
  output logic       grant_four_pair
);
  logic              take_evt, snap_new, snap_span;
  logic [CODE_W-1:0] snap_code;

  strap_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .strap_code(strap_code), .span_strap(span_strap),
    .uvlo_clear(uvlo_clear), .otemp_clear(otemp_clear), .take_evt(take_evt),
    .snap_new(snap_new), .snap_code(snap_code), .snap_span(snap_span)
  );

  cfg_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .take_evt(take_evt), .snap_new(snap_new),
    .snap_code(snap_code), .snap_span(snap_span), .cfg_valid(cfg_valid),
    .max_class(max_class), .four_pair(four_pair), .cfg_error(cfg_error)
  );

  assign detect_en = cfg_valid && !cfg_error;

  grant_stage u_gnt (
    .clk(clk), .rst_n(rst_n), .usable(detect_en), .max_class(max_class),
    .four_pair(four_pair), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .grant_valid(grant_valid), .grant_ready(grant_ready),
    .grant_class(grant_class), .grant_four_pair(grant_four_pair)
  );

  // R7
  detect_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cfg_valid && !cfg_error));
endmodule

// File: tb/pwr_strap_cfg_tb.sv
module pwr_strap_cfg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap_code = 3'b111;
  logic       span_strap = 1'b1;
  logic       uvlo_clear = 1'b0, otemp_clear = 1'b0;
  logic       cfg_valid, four_pair, cfg_error, detect_en;
  logic [3:0] max_class;
  logic       req_valid = 1'b0, req_ready, grant_valid, grant_ready = 1'b1, grant_four_pair;
  logic [3:0] req_class = '0, grant_class;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pwr_strap_cfg u_dut (.*);

  function automatic int e_max(input logic [2:0] c, input logic s);
    if (c >= 3'b100) return int'(c) + 1;
    if (c == 3'b011) return s ? 4 : 0;
    return int'(c) + 2;
  endfunction
  function automatic logic e_quad(input logic [2:0] c, input logic s);
    return (c >= 3'b100) || (c == 3'b011 && s);
  endfunction
  function automatic logic e_err(input logic [2:0] c, input logic s);
    return (c == 3'b011) && !s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_cfg(input string req, input logic [2:0] c, input logic s);
    chk({req, " valid"}, cfg_valid, 1);
    chk({req, " max_class"}, max_class, e_max(c, s));
    chk({req, " four_pair"}, four_pair, e_quad(c, s));
    chk({req, " cfg_error"}, cfg_error, e_err(c, s));
    chk("R7 detect_en", detect_en, !e_err(c, s));
  endtask

  task automatic resample(input logic [2:0] c, input logic s, input bit use_ot);
    strap_code = c; span_strap = s;
    if (use_ot) otemp_clear = 1'b1; else uvlo_clear = 1'b1;
    step(1);
    uvlo_clear = 1'b0; otemp_clear = 1'b0;
    chk("R2 valid low after event", cfg_valid, 0);
    step(1);
  endtask

  task automatic one_req(input int rc, input logic [2:0] c, input logic s);
    int g;
    req_class = 4'(rc); req_valid = 1'b1; grant_ready = 1'b1;
    chk("R10 req_ready", req_ready, !e_err(c, s));
    step(1);
    req_valid = 1'b0;
    if (!e_err(c, s)) begin
      g = (rc > e_max(c, s)) ? e_max(c, s) : rc;
      chk("R10 grant_valid", grant_valid, 1);
      chk("R8 grant_class", grant_class, g);
      chk("R9 grant_four_pair", grant_four_pair, e_quad(c, s) && g >= 4);
    end else begin
      chk("R5 no grant when reserved", grant_valid, 0);
    end
    step(1);
    chk("R10 grant drained", grant_valid, 0);
  endtask

  initial begin
    step(1);
    chk("R1 reset valid", cfg_valid, 0);
    chk("R1 reset max_class", max_class, 0);
    chk("R1 reset detect_en", detect_en, 0);
    chk("R1 reset grant_valid", grant_valid, 0);
    rst_n = 1'b1;
    step(1);
    strap_code = 3'b000; span_strap = 1'b0;
    chk("R1 not valid after one edge", cfg_valid, 0);
    step(1);
    chk_cfg("R1 R4 boot code 111", 3'b111, 1'b1);
    step(3);
    chk("R3 ignored change max_class", max_class, 8);
    chk("R3 ignored change four_pair", four_pair, 1);

    // R5 reserved, then R5 legal span high
    resample(3'b011, 1'b0, 1'b0);
    chk_cfg("R5 reserved", 3'b011, 1'b0);
    one_req(4, 3'b011, 1'b0);
    resample(3'b011, 1'b1, 1'b1);
    chk_cfg("R5 span high", 3'b011, 1'b1);
    one_req(4, 3'b011, 1'b1);
    one_req(3, 3'b011, 1'b1);

    // R9 forced four-pair for class 4 under class 6 max
    resample(3'b101, 1'b0, 1'b0);
    chk_cfg("R4 code 101", 3'b101, 1'b0);
    one_req(4, 3'b101, 1'b0);
    one_req(8, 3'b101, 1'b0);

    // R6 two-pair, demotion
    resample(3'b001, 1'b1, 1'b1);
    chk_cfg("R6 code 001", 3'b001, 1'b1);
    one_req(4, 3'b001, 1'b1);

    // R10 stall
    resample(3'b110, 1'b1, 1'b0);
    grant_ready = 1'b0; req_valid = 1'b1; req_class = 4'd8;
    step(1);
    req_class = 4'd2;
    chk("R10 ready drops when full", req_ready, 0);
    step(3);
    chk("R10 stalled grant_class", grant_class, 7);
    chk("R10 stalled grant_valid", grant_valid, 1);
    chk("R10 stalled four_pair", grant_four_pair, 1);
    grant_ready = 1'b1;
    step(1);
    req_valid = 1'b0;
    chk("R10 next grant class", grant_class, 2);
    chk("R9 next grant two-pair", grant_four_pair, 0);
    step(1);

    // random mix with fixed seed
    void'($urandom(32'd4711));
    for (int i = 0; i < 60; i++) begin
      logic [2:0] c;
      logic s;
      c = 3'($urandom_range(0, 7));
      s = 1'($urandom_range(0, 1));
      resample(c, s, 1'($urandom_range(0, 1)));
      chk_cfg("R4 R5 R6 random decode", c, s);
      strap_code = ~c; span_strap = ~s;
      step(2);
      chk("R3 random ignored max_class", max_class, e_max(c, s));
      chk("R3 random ignored error", cfg_error, e_err(c, s));
      for (int k = 0; k < 3; k++) one_req($urandom_range(0, 9), c, s);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule